// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block keeps the sixteen most recently installed virtual-to-physical page translations. Instruction and data references use the same set of entries. A lookup presents a 32-bit virtual address. The upper 20 bits, the virtual page number, are compared against every stored tag in the same cycle. On a match the block returns the 32-bit physical address right away and marks the entry as used. A store that hits also marks the entry as modified.

When a lookup misses, the failing page number is captured in a register for the miss handler. The block also offers a replacement slot. It picks the lowest-numbered empty slot if one exists; otherwise a rotating pointer chooses the slot. The modified and used bits of that slot are shown on the outputs, so the handler can copy them back to the page table before it installs the new translation through the refill port. Two further operations are available: a single-cycle flush of every entry, and invalidation of the one entry whose tag equals a supplied page number.

Top module: `xlate_buf`

## Requirements
- R1: After reset no entry is valid, the captured miss page number is 0 and the rotating pointer is 0, so the offered slot index is 0.
- R2: `hit` is 1 in the same cycle exactly when `lk_en` is 1 and a valid entry's tag equals `lk_vaddr[31:12]`. On a hit, `paddr` is {entry page frame, `lk_vaddr[11:0]`}. With no hit, `paddr` is 0.
- R3: At the clock edge ending a hitting lookup, the entry's used bit is set. If `lk_store` is 1 the modified bit is also set. A lookup with `lk_store` 0 leaves the modified bit unchanged.
- R4: A lookup that misses loads `lk_vaddr[31:12]` into `miss_vpn` at that edge. A hit leaves `miss_vpn` unchanged.
- R5: `vic_idx` is the lowest index of an invalid entry. If all entries are valid, it is the rotating pointer. The pointer advances by one, modulo 16, on every accepted refill.
- R6: `vic_dirty` and `vic_ref` show the stored modified and used bits of the entry at `vic_idx`, combinationally.
- R7: An accepted refill writes `fill_vpn` and `fill_ppn` into the offered slot with valid=1. Its modified and used bits are taken from `fill_dirty` and `fill_ref`, so they are 0 unless supplied as 1.
- R8: A refill whose page number equals the tag of a valid entry overwrites that entry instead of the offered slot. A tag is therefore never held by two valid entries.
- R9: Invalidate clears the valid, modified and used bits of only the entry whose tag equals `inval_vpn`.
- R10: `flush` clears all entries in one cycle. A refill presented in the same cycle is dropped, and the pointer holds.
- R11: When several operations reach the same entry in one cycle, refill wins over invalidate, and invalidate wins over the status update from a hit. Operations on different entries all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_en | input | 1 | Lookup request this cycle |
| lk_store | input | 1 | Lookup is a store |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| hit | output | 1 | Lookup matched a valid entry |
| paddr | output | 32 | Translated physical address |
| miss_vpn | output | 20 | Page number of the last missing lookup |
| vic_idx | output | 4 | Slot the next refill replaces |
| vic_dirty | output | 1 | Modified bit of that slot |
| vic_ref | output | 1 | Used bit of that slot |
| fill_en | input | 1 | Refill request |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_ppn | input | 20 | Refill physical page frame |
| fill_dirty | input | 1 | Modified bit for the refilled entry |
| fill_ref | input | 1 | Used bit for the refilled entry |
| inval_en | input | 1 | Invalidate request |
| inval_vpn | input | 20 | Page number to invalidate |
| flush | input | 1 | Invalidate every entry |

## Verification
A hitting lookup can share its cycle with a refill or an invalidate, because all three write the entry array at the same edge. The bench drives a store hit on one entry together with a refill into an empty slot. It then moves the rotating pointer onto the stored-to entry and checks through the slot outputs that the modified and used bits were kept, and it checks that the refilled translation can be looked up. It also drives a read hit and an invalidate of the same page in one cycle. It expects `hit` to be 1 during that cycle, a miss afterwards, and the slot outputs to show that entry empty with its used bit clear.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int VPN_W = 20;
    localparam int PPN_W = 20;
    localparam int OFF_W = 12;
    localparam int VA_W  = VPN_W + OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;
    localparam int NENT  = 16;
    localparam int IDX_W = $clog2(NENT);

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic             refd;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } xlate_ent_t;

    // lowest set bit position; 0 when none is set
    function automatic logic [IDX_W-1:0] lowest_set(input logic [NENT-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = NENT - 1; i >= 0; i--)
            if (v[i]) r = IDX_W'(i);
        return r;
    endfunction
endpackage

// File: rtl/xlate_cam.sv
module xlate_cam #(
    parameter int N  = 16,
    parameter int W  = 20,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0][W-1:0] tags,
    input  logic [N-1:0]        valid,
    input  logic [W-1:0]        key,
    output logic [N-1:0]        match,
    output logic [IW-1:0]       idx,
    output logic                any
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (match[i]) idx = IW'(i);
    end

    assign any = |match;
endmodule

// File: rtl/xlate_victim.sv
module xlate_victim
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic [NENT-1:0]  valid,
    output logic [IDX_W-1:0] vic_idx
);
    logic [IDX_W-1:0] ptr;
    logic [NENT-1:0]  empty;

    assign empty   = ~valid;
    assign vic_idx = (|empty) ? lowest_set(empty) : ptr;

    always_ff @(posedge clk) begin
        if (rst)          ptr <= '0;
        else if (advance) ptr <= ptr + 1'b1;
    end

    a_r5_ptr_step: assert property (@(posedge clk) disable iff (rst)
        advance |=> ptr == $past(ptr) + 1'b1);
    a_r5_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(ptr));
    a_r5_empty_first: assert property (@(posedge clk) disable iff (rst)
        (|empty) |-> !valid[vic_idx]);
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_en,
    input  logic             lk_store,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             hit,
    output logic [PA_W-1:0]  paddr,
    output logic [VPN_W-1:0] miss_vpn,
    output logic [IDX_W-1:0] vic_idx,
    output logic             vic_dirty,
    output logic             vic_ref,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_dirty,
    input  logic             fill_ref,
    input  logic             inval_en,
    input  logic [VPN_W-1:0] inval_vpn,
    input  logic             flush
);
    xlate_ent_t ent [NENT];

    logic [NENT-1:0][VPN_W-1:0] tags;
    logic [NENT-1:0]            valid_vec;

    always_comb begin
        for (int i = 0; i < NENT; i++) begin
            tags[i]      = ent[i].vpn;
            valid_vec[i] = ent[i].valid;
        end
    end

    logic [VPN_W-1:0] lk_vpn;
    logic [NENT-1:0]  look_match, fill_match, inv_match;
    logic [IDX_W-1:0] look_idx, fill_hit_idx, inv_idx;
    logic             look_any, fill_any, inv_any;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

    xlate_cam #(.N(NENT), .W(VPN_W)) u_look (
        .tags(tags), .valid(valid_vec), .key(lk_vpn),
        .match(look_match), .idx(look_idx), .any(look_any));
    xlate_cam #(.N(NENT), .W(VPN_W)) u_fillm (
        .tags(tags), .valid(valid_vec), .key(fill_vpn),
        .match(fill_match), .idx(fill_hit_idx), .any(fill_any));
    xlate_cam #(.N(NENT), .W(VPN_W)) u_inv (
        .tags(tags), .valid(valid_vec), .key(inval_vpn),
        .match(inv_match), .idx(inv_idx), .any(inv_any));

    logic             fill_go;
    logic [IDX_W-1:0] fill_idx;

    assign fill_go  = fill_en && !flush;
    assign fill_idx = fill_any ? fill_hit_idx : vic_idx;

    xlate_victim u_vic (
        .clk(clk), .rst(rst), .advance(fill_go),
        .valid(valid_vec), .vic_idx(vic_idx));

    assign hit       = lk_en && look_any;
    assign paddr     = hit ? {ent[look_idx].ppn, lk_vaddr[OFF_W-1:0]} : '0;
    assign vic_dirty = ent[vic_idx].dirty;
    assign vic_ref   = ent[vic_idx].refd;

    always_ff @(posedge clk) begin
        if (rst) begin
            miss_vpn <= '0;
            for (int i = 0; i < NENT; i++) ent[i] <= '0;
        end else begin
            if (lk_en && !look_any) miss_vpn <= lk_vpn;
            for (int i = 0; i < NENT; i++) begin
                if (flush) begin
                    ent[i].valid <= 1'b0;
                    ent[i].dirty <= 1'b0;
                    ent[i].refd  <= 1'b0;
                end else if (fill_go && fill_idx == IDX_W'(i)) begin
                    ent[i] <= '{valid: 1'b1, dirty: fill_dirty, refd: fill_ref,
                                vpn: fill_vpn, ppn: fill_ppn};
                end else if (inval_en && inv_match[i]) begin
                    ent[i].valid <= 1'b0;
                    ent[i].dirty <= 1'b0;
                    ent[i].refd  <= 1'b0;
                end else if (hit && look_match[i]) begin
                    ent[i].refd <= 1'b1;
                    if (lk_store) ent[i].dirty <= 1'b1;
                end
            end
        end
    end

    a_r4_miss_latch: assert property (@(posedge clk) disable iff (rst)
        (lk_en && !hit) |=> miss_vpn == $past(lk_vpn));
    a_r4_hit_keeps: assert property (@(posedge clk) disable iff (rst)
        hit |=> $stable(miss_vpn));
    a_r8_unique_tag: assert property (@(posedge clk) disable iff (rst)
        $onehot0(look_match));
    a_r10_flush_all: assert property (@(posedge clk) disable iff (rst)
        flush |=> valid_vec == '0);
    a_r7_fill_lands: assert property (@(posedge clk) disable iff (rst)
        fill_go |=> valid_vec[$past(fill_idx)] && tags[$past(fill_idx)] == $past(fill_vpn));
    a_r3_ref_set: assert property (@(posedge clk) disable iff (rst)
        (hit && !flush && !fill_go && !inval_en) |=> ent[$past(look_idx)].refd);
    a_r9_inval_clears: assert property (@(posedge clk) disable iff (rst)
        (inval_en && inv_any && !flush && !fill_go) |=> !valid_vec[$past(inv_idx)]);
endmodule

// File: tb/xlate_buf_test.sv
module xlate_buf_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_en, lk_store;
    logic [31:0] lk_vaddr;
    logic        hit;
    logic [31:0] paddr;
    logic [19:0] miss_vpn;
    logic [3:0]  vic_idx;
    logic        vic_dirty, vic_ref;
    logic        fill_en, fill_dirty, fill_ref, inval_en, flush;
    logic [19:0] fill_vpn, fill_ppn, inval_vpn;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    xlate_buf uut (
        .clk(clk), .rst(rst), .lk_en(lk_en), .lk_store(lk_store), .lk_vaddr(lk_vaddr),
        .hit(hit), .paddr(paddr), .miss_vpn(miss_vpn), .vic_idx(vic_idx),
        .vic_dirty(vic_dirty), .vic_ref(vic_ref), .fill_en(fill_en), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_dirty(fill_dirty), .fill_ref(fill_ref),
        .inval_en(inval_en), .inval_vpn(inval_vpn), .flush(flush));

    typedef struct packed {
        logic [31:0] va;
        logic        st;
        logic        eh;
        logic [31:0] pa;
    } vec_t;

    localparam vec_t VT [6] = '{
        '{32'h00100ABC, 1'b0, 1'b1, 32'h00800ABC},
        '{32'h0010FFFF, 1'b1, 1'b1, 32'h0080FFFF},
        '{32'h00200123, 1'b0, 1'b0, 32'h00000000},
        '{32'h00107000, 1'b0, 1'b1, 32'h00807000},
        '{32'h12345678, 1'b1, 1'b0, 32'h00000000},
        '{32'h00100001, 1'b1, 1'b1, 32'h00800001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        lk_en = 0; lk_store = 0; lk_vaddr = '0;
        fill_en = 0; fill_vpn = '0; fill_ppn = '0; fill_dirty = 0; fill_ref = 0;
        inval_en = 0; inval_vpn = '0; flush = 0;
    endtask

    task automatic settle();
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic look(input logic [31:0] va, input bit st, input bit eh,
                        input logic [31:0] epa, input string req);
        @(negedge clk);
        idle();
        lk_en = 1; lk_store = st; lk_vaddr = va;
        #1;
        check(req, {31'b0, hit}, {31'b0, eh});
        check(req, paddr, eh ? epa : 32'h0);
        if (!eh) begin
            settle();
            check({req, " R4 miss page"}, {12'b0, miss_vpn}, {12'b0, va[31:12]});
        end
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input bit d, input bit r);
        @(negedge clk);
        idle();
        fill_en = 1; fill_vpn = vpn; fill_ppn = ppn; fill_dirty = d; fill_ref = r;
    endtask

    task automatic vic(input int idx, input bit d, input bit r, input string req);
        settle();
        check({req, " slot"}, {28'b0, vic_idx}, idx);
        check({req, " dirty"}, {31'b0, vic_dirty}, {31'b0, d});
        check({req, " used"}, {31'b0, vic_ref}, {31'b0, r});
    endtask

    task automatic step_ptr(input int n);
        for (int k = 0; k < n; k++) fill(20'h00100, 20'h00800, 1'b0, 1'b0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        vic(0, 1'b0, 1'b0, "R1 reset");
        check("R1 miss reg", {12'b0, miss_vpn}, 32'h0);
        look(32'h00100000, 1'b0, 1'b0, 32'h0, "R1 empty lookup");

        // R5 empty-first, R7 supplied bits
        for (int i = 0; i < 16; i++) begin
            settle();
            check("R5 empty slot first", {28'b0, vic_idx}, i);
            fill(20'h00100 + 20'(i), 20'h00800 + 20'(i), i == 3, i == 4);
        end

        // R2 R4 vector walk
        for (int v = 0; v < 6; v++)
            look(VT[v].va, VT[v].st, VT[v].eh, VT[v].pa, "R2 vector");

        // R3 R6: pointer at 0, entry 0 read then written
        vic(0, 1'b1, 1'b1, "R3 R6 entry0 status");

        // R8 duplicate refill hits entry 15, not slot 0
        fill(20'h0010F, 20'h00777, 1'b0, 1'b0);
        look(32'h0010F123, 1'b0, 1'b1, 32'h00777123, "R8 dup refill");
        look(32'h00100123, 1'b0, 1'b1, 32'h00800123, "R8 slot0 kept");
        step_ptr(2);
        vic(3, 1'b1, 1'b0, "R7 supplied dirty");
        step_ptr(1);
        vic(4, 1'b0, 1'b1, "R7 supplied used");
        step_ptr(1);
        vic(5, 1'b0, 1'b0, "R3 untouched entry");
        step_ptr(10);
        vic(15, 1'b0, 1'b1, "R7 refill cleared dirty");

        // R5 R7 replacement of round-robin slot
        fill(20'h00300, 20'h00123, 1'b0, 1'b0);
        look(32'h00300456, 1'b0, 1'b1, 32'h00123456, "R7 refilled");
        look(32'h0010F000, 1'b0, 1'b0, 32'h0, "R7 replaced gone");
        vic(0, 1'b0, 1'b0, "R5 pointer wrapped");

        // R9 invalidate one entry
        @(negedge clk);
        idle();
        inval_en = 1; inval_vpn = 20'h00105;
        vic(5, 1'b0, 1'b0, "R9 invalidated slot");
        look(32'h00105000, 1'b0, 1'b0, 32'h0, "R9 gone");
        look(32'h00106000, 1'b0, 1'b1, 32'h00806000, "R9 neighbour kept");

        // R11 store hit plus refill in one cycle
        @(negedge clk);
        idle();
        lk_en = 1; lk_store = 1; lk_vaddr = 32'h00102ABC;
        fill_en = 1; fill_vpn = 20'h00500; fill_ppn = 20'h000AA;
        #1;
        check("R11 hit during refill", {31'b0, hit}, 32'h1);
        check("R11 pa during refill", paddr, 32'h00802ABC);
        look(32'h00500FFF, 1'b0, 1'b1, 32'h000AAFFF, "R11 refill landed");
        vic(1, 1'b0, 1'b0, "R11 pointer");
        step_ptr(1);
        vic(2, 1'b1, 1'b1, "R11 store status kept");

        // R11 hit and invalidate on same entry
        @(negedge clk);
        idle();
        lk_en = 1; lk_vaddr = 32'h00106000;
        inval_en = 1; inval_vpn = 20'h00106;
        #1;
        check("R11 hit before invalidate", {31'b0, hit}, 32'h1);
        look(32'h00106000, 1'b0, 1'b0, 32'h0, "R11 invalidate wins");
        vic(6, 1'b0, 1'b0, "R11 used bit cleared");

        // R10 flush with a refill in the same cycle
        @(negedge clk);
        idle();
        flush = 1; fill_en = 1; fill_vpn = 20'h00600; fill_ppn = 20'h00321;
        look(32'h00100000, 1'b0, 1'b0, 32'h0, "R10 flushed");
        look(32'h00600000, 1'b0, 1'b0, 32'h0, "R10 refill dropped");
        vic(0, 1'b0, 1'b0, "R10 all empty");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule